// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss without software help. When the translation buffer misses, it passes the walker a virtual page number and the kind of access that was attempted. The walker adds the page number, scaled by the entry size, to a base register to form the entry's physical address. It makes one read through a plain request/response memory port and decodes the returned entry.

An entry may be absent, or present but lacking the right the access needs, or present and allowing it. In the first two cases the walker raises a page fault or a protection fault, and the translation buffer is left untouched. In the third case it presents a one-cycle refill record: page number, physical page number and rights.

The walker handles a single miss at a time. The base register is written through a separate port and changes only while no walk is in flight.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `req_ready` is 1 and `mem_req_valid`, `fill_valid`, `page_fault` and `prot_fault` are all 0.
- R2: After a request is accepted, `mem_req_valid` rises in the next cycle with `mem_req_addr` = base + VPN × 4, computed modulo 2^PA_W. The request stays valid with a stable address until the cycle in which `mem_req_ready` is high, and it drops in the cycle after that.
- R3: `req_ready` falls in the cycle after a request is accepted and stays low until the cycle in which the result is presented. Requests offered while it is low have no effect.
- R4: Entry layout: bit 0 is the valid flag, bit 1 allows reads, bit 2 allows writes, bit 3 allows execution, and bits [8+PPN_W-1:8] hold the physical page number. When a valid entry allows the access, `fill_valid` is 1 for exactly the one cycle after `mem_rsp_valid`. In that cycle `res_vpn` is the requested VPN, `fill_ppn` is the entry's page number and `fill_rights` is entry bits [3:1].
- R5: When entry bit 0 is 0, `page_fault` is 1 for the one cycle after the response and no refill is given, whatever the rights bits hold.
- R6: Access codes are 0 = read, 1 = write, 2 = execute and 3 = never allowed. When a valid entry lacks the needed right, `prot_fault` is 1 for the one cycle after the response and no refill is given.
- R7: Every walk ends with exactly one of `fill_valid`, `page_fault` and `prot_fault` high for a single cycle. None of them is high while the walk is still in progress.
- R8: `base_we` loads `base_wdata` into the base register only in a cycle where `req_ready` is 1. A write offered while a walk is in flight has no effect on the base register.
- R9: When a base write and a request acceptance happen in the same cycle, that walk uses the previous base value. The new value applies from the next walk onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Privileged write strobe for the table base register |
| base_wdata | input | PA_W | New table base address |
| req_valid | input | 1 | Translation miss offered |
| req_vpn | input | VPN_W | Virtual page number that missed |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 never allowed |
| req_ready | output | 1 | Walker idle and able to take a miss |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | PA_W | Physical address of the entry |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 8*PTE_BYTES | Entry word |
| fill_valid | output | 1 | Refill record valid (one cycle) |
| res_vpn | output | VPN_W | Page number of the finished walk |
| fill_ppn | output | PPN_W | Physical page number for the refill |
| fill_rights | output | 3 | Rights for the refill: read, write, execute |
| page_fault | output | 1 | Entry absent (one cycle) |
| prot_fault | output | 1 | Access not allowed by entry (one cycle) |

## Verification
Two pairs of events can land in the same cycle. The first pair is a base-register write and the acceptance of a miss. The bench issues both on one edge and checks that the address read for that walk still uses the old base, while the walk after it uses the new one. The second pair is the arrival of a response while a new miss is waiting, and also base writes made during a walk. The bench holds a new miss and a base write in the cycles before the response. It then judges, from the next read address and from `res_vpn`, that neither the miss nor the write was taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_FILL   = 2'd1,
        OUT_PFAULT = 2'd2,
        OUT_PROT   = 2'd3
    } outcome_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam int PTE_VALID_BIT  = 0;
    localparam int PTE_RIGHTS_LSB = 1;
    localparam int PTE_PPN_LSB    = 8;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VPN_W     = 6,
    parameter int PA_W      = 16,
    parameter int PTE_BYTES = 4
) (
    input  logic [PA_W-1:0]  base_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic [PA_W-1:0]  addr_o
);
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [PA_W-1:0] offset;

    // Entry index scaled to a byte offset; sum wraps at the address width.
    assign offset = PA_W'(vpn_i) << SHIFT;
    assign addr_o = base_i + offset;

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PPN_W   = 8,
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [1:0]         acc_i,
    output outcome_e           verdict_o,
    output logic [PPN_W-1:0]   ppn_o,
    output logic [2:0]         rights_o
);
    logic permitted;
    logic unused_bits;

    assign rights_o    = entry_i[PTE_RIGHTS_LSB +: 3];
    assign ppn_o       = entry_i[PTE_PPN_LSB +: PPN_W];
    assign unused_bits = ^{entry_i[PTE_PPN_LSB-1:PTE_RIGHTS_LSB+3],
                           entry_i[ENTRY_W-1:PTE_PPN_LSB+PPN_W]};

    always_comb begin
        case (acc_i)
            ACC_READ:  permitted = rights_o[0];
            ACC_WRITE: permitted = rights_o[1];
            ACC_EXEC:  permitted = rights_o[2];
            default:   permitted = 1'b0;
        endcase
    end

    // An absent entry outranks a rights mismatch.
    always_comb begin
        if (!entry_i[PTE_VALID_BIT]) begin
            verdict_o = OUT_PFAULT;
        end else if (permitted) begin
            verdict_o = OUT_FILL;
        end else begin
            verdict_o = OUT_PROT;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W     = 6,
    parameter int PPN_W     = 8,
    parameter int PA_W      = 16,
    parameter int PTE_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_we,
    input  logic [PA_W-1:0]          base_wdata,
    input  logic                     req_valid,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [1:0]               req_acc,
    output logic                     req_ready,
    output logic                     mem_req_valid,
    output logic [PA_W-1:0]          mem_req_addr,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    input  logic [8*PTE_BYTES-1:0]   mem_rsp_data,
    output logic                     fill_valid,
    output logic [VPN_W-1:0]         res_vpn,
    output logic [PPN_W-1:0]         fill_ppn,
    output logic [2:0]               fill_rights,
    output logic                     page_fault,
    output logic                     prot_fault
);
    localparam int ENTRY_W = 8 * PTE_BYTES;

    typedef struct packed {
        walk_st_e         st;
        logic [PA_W-1:0]  base;
        logic [PA_W-1:0]  addr;
        logic [VPN_W-1:0] vpn;
        logic [1:0]       acc;
        logic             fill;
        logic             pfault;
        logic             pfprot;
        logic [PPN_W-1:0] ppn;
        logic [2:0]       rights;
    } walk_t;

    walk_t cur_q, nxt_d;

    logic [PA_W-1:0]  entry_addr;
    outcome_e         verdict;
    logic [PPN_W-1:0] entry_ppn;
    logic [2:0]       entry_rights;

    ptw_addr_gen #(
        .VPN_W     (VPN_W),
        .PA_W      (PA_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_addr (
        .base_i (cur_q.base),
        .vpn_i  (req_vpn),
        .addr_o (entry_addr)
    );

    ptw_pte_check #(
        .PPN_W   (PPN_W),
        .ENTRY_W (ENTRY_W)
    ) u_pte (
        .entry_i   (mem_rsp_data),
        .acc_i     (cur_q.acc),
        .verdict_o (verdict),
        .ppn_o     (entry_ppn),
        .rights_o  (entry_rights)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.fill   = 1'b0;
        nxt_d.pfault = 1'b0;
        nxt_d.pfprot = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (base_we) begin
                    nxt_d.base = base_wdata;
                end
                if (req_valid) begin
                    nxt_d.st   = ST_ISSUE;
                    nxt_d.addr = entry_addr;   // old base, even if written now
                    nxt_d.vpn  = req_vpn;
                    nxt_d.acc  = req_acc;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    nxt_d.st = ST_IDLE;
                    case (verdict)
                        OUT_FILL: begin
                            nxt_d.fill   = 1'b1;
                            nxt_d.ppn    = entry_ppn;
                            nxt_d.rights = entry_rights;
                        end
                        OUT_PFAULT: nxt_d.pfault = 1'b1;
                        OUT_PROT:   nxt_d.pfprot = 1'b1;
                        default:    nxt_d.pfault = 1'b0;
                    endcase
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready     = (cur_q.st == ST_IDLE);
    assign mem_req_valid = (cur_q.st == ST_ISSUE);
    assign mem_req_addr  = cur_q.addr;
    assign fill_valid    = cur_q.fill;
    assign page_fault    = cur_q.pfault;
    assign prot_fault    = cur_q.pfprot;
    assign res_vpn       = cur_q.vpn;
    assign fill_ppn      = cur_q.ppn;
    assign fill_rights   = cur_q.rights;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VPN_W     = 6,
    parameter int PA_W      = 16,
    parameter int PTE_BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   mem_req_valid,
    input logic [PA_W-1:0]        mem_req_addr,
    input logic                   mem_req_ready,
    input logic                   mem_rsp_valid,
    input logic [8*PTE_BYTES-1:0] mem_rsp_data,
    input logic                   fill_valid,
    input logic [VPN_W-1:0]       res_vpn,
    input logic                   page_fault,
    input logic                   prot_fault
);
    logic any_result;
    assign any_result = fill_valid | page_fault | prot_fault;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R3

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_valid, page_fault, prot_fault})); // R7

    AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        any_result |-> $past(mem_rsp_valid) && req_ready); // R7

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid); // R4

    AST_FILL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(mem_rsp_data[0])); // R4

    AST_PFAULT_ON_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault |-> !$past(mem_rsp_data[0])); // R5

    AST_PROT_ON_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> $past(mem_rsp_data[0])); // R6

    AST_VPN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> $stable(res_vpn)); // R3

endmodule

bind ptw_walker ptw_walker_chk #(
    .VPN_W     (VPN_W),
    .PA_W      (PA_W),
    .PTE_BYTES (PTE_BYTES)
) u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_valid    (fill_valid),
    .res_vpn       (res_vpn),
    .page_fault    (page_fault),
    .prot_fault    (prot_fault)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    localparam int VPN_W = 6;
    localparam int PPN_W = 8;
    localparam int PA_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_we = 1'b0;
    logic [PA_W-1:0]  base_wdata = '0;
    logic             req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [1:0]       req_acc = '0;
    logic             req_ready;
    logic             mem_req_valid;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_req_ready = 1'b0;
    logic             mem_rsp_valid = 1'b0;
    logic [31:0]      mem_rsp_data = '0;
    logic             fill_valid;
    logic [VPN_W-1:0] res_vpn;
    logic [PPN_W-1:0] fill_ppn;
    logic [2:0]       fill_rights;
    logic             page_fault;
    logic             prot_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [PA_W-1:0] exp_base = '0;

    always #2.5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_acc(req_acc), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .res_vpn(res_vpn),
        .fill_ppn(fill_ppn), .fill_rights(fill_rights), .page_fault(page_fault),
        .prot_fault(prot_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Table content: flags from vpn[3:0], page number from an arithmetic scramble.
    function automatic logic [31:0] pte_of(input logic [5:0] vpn);
        logic [7:0] ppn;
        ppn = 8'(vpn * 37 + 11);
        return {16'h0, ppn, 4'h0, vpn[3:0]};
    endfunction

    task automatic walk(input logic [5:0] vpn, input logic [1:0] acc, input int rdly,
                        input int sdly, input int bw_mode, input logic [15:0] bw_val,
                        input string atag);
        logic [31:0] e;
        logic        allowed;
        logic [15:0] exp_addr;
        e = pte_of(vpn);
        case (acc)
            2'd0: allowed = e[1];
            2'd1: allowed = e[2];
            2'd2: allowed = e[3];
            default: allowed = 1'b0;
        endcase
        exp_addr = exp_base + 16'(vpn) * 16'd4;
        if (bw_mode == 2 && sdly == 0) sdly = 1;

        @(negedge clk);
        chk("R3", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vpn = vpn; req_acc = acc;
        if (bw_mode == 1) begin base_we = 1'b1; base_wdata = bw_val; end
        @(negedge clk);
        req_valid = 1'b0; base_we = 1'b0;
        chk("R3", 32'(req_ready), 32'd0);
        chk("R2", 32'(mem_req_valid), 32'd1);
        chk(atag, 32'(mem_req_addr), 32'(exp_addr));
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk("R2", 32'(mem_req_valid), 32'd1);
            chk("R2", 32'(mem_req_addr), 32'(exp_addr));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R2", 32'(mem_req_valid), 32'd0);
        for (int i = 0; i < sdly; i++) begin
            if (bw_mode == 2 && i == 0) begin base_we = 1'b1; base_wdata = bw_val; end
            req_valid = 1'b1; req_vpn = ~vpn; req_acc = 2'd0;
            @(negedge clk);
            base_we = 1'b0;
            chk("R3", 32'(req_ready), 32'd0);
            chk("R7", 32'({fill_valid, page_fault, prot_fault}), 32'd0);
        end
        req_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = e;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hffff_ffff;
        chk("R3", 32'(req_ready), 32'd1);
        chk("R5", 32'(page_fault), 32'(!e[0]));
        chk("R6", 32'(prot_fault), 32'(e[0] && !allowed));
        chk("R4", 32'(fill_valid), 32'(e[0] && allowed));
        chk("R4", 32'(res_vpn), 32'(vpn));
        if (e[0] && allowed) begin
            chk("R4", 32'(fill_ppn), 32'(e[15:8]));
            chk("R4", 32'(fill_rights), 32'(e[3:1]));
        end
        @(negedge clk);
        chk("R7", 32'({fill_valid, page_fault, prot_fault}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tag_next;
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        chk("R1", 32'({req_ready, mem_req_valid, fill_valid, page_fault, prot_fault}), 32'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'({req_ready, mem_req_valid, fill_valid, page_fault, prot_fault}), 32'b10000);

        // R8: write while idle is taken
        base_we = 1'b1; base_wdata = 16'h1200;
        @(negedge clk);
        base_we = 1'b0;
        exp_base = 16'h1200;
        tag_next = "R8";

        for (int v = 0; v < 64; v++) begin
            for (int a = 0; a < 4; a++) begin
                int mode;
                logic [15:0] val;
                string t;
                mode = 0; val = '0; t = tag_next; tag_next = "R2";
                if (v % 16 == 5 && a == 0) begin
                    mode = 2; val = exp_base ^ 16'h0f00;
                end else if (v % 16 == 9 && a == 1) begin
                    mode = 1; val = exp_base + 16'h0400; t = "R9";
                end
                walk(6'(v), 2'(a), (v + a) % 3, (v * a) % 4, mode, val, t);
                if (mode == 2) tag_next = "R8";
                if (mode == 1) begin exp_base = val; tag_next = "R9"; end
            end
        end

        // Wraparound of the address sum at the top of the address space.
        @(negedge clk);
        base_we = 1'b1; base_wdata = 16'hfff0;
        @(negedge clk);
        base_we = 1'b0; exp_base = 16'hfff0;
        walk(6'd63, 2'd0, 0, 0, 0, 16'h0, "R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule